// File: doc/BRIEF.md
# Multi-Mode Floating-Point Minimum/Maximum Unit

This block is a purely combinational datapath that returns either the smaller or the larger of two binary64 operands. A 4-bit mode field selects one of sixteen variants. Each variant is defined by three choices: minimum or maximum, signed-value or magnitude comparison, and one of four policies for NaN inputs. The policies are a number-preferring form in the 2008 style, a NaN-propagating form in the 2019 style, a number-preferring form in the 2019 style, and a plain compare-and-select form that ignores NaN semantics.

The unit reports whether either operand was a signaling NaN. It also produces a write-enable that a surrounding register file uses to drop the result when invalid-operation trapping is on or when a signaling NaN was seen. Status accumulation, condition codes and operand storage live outside the block.

Top module: `fmm_unit`

## Requirements
- R1: When neither operand is NaN, mode bit 3 = 0 returns the smaller operand and mode bit 3 = 1 returns the larger one. Ordering is sign-magnitude: any negative pattern is below any positive pattern, and among negatives the larger unsigned pattern is smaller. On a tie the result is operand B, bit-exact. Subnormals and infinities follow the same ordering.
- R2: An operand is NaN when its bits 62:0, read as unsigned, exceed 0x7FF0_0000_0000_0000. A NaN is signaling when bit 51 is 0. A quieted copy is the operand with bit 51 set.
- R3: Policy bits 1:0 = 00 with a NaN input returns a value chosen in this priority order: quieted A if A is signaling; else quieted B if B is signaling; else quieted A if both are NaN; else the operand that is not NaN.
- R4: Policy 01 with any NaN input returns quieted A if A is NaN, otherwise quieted B.
- R5: Policy 10 with a NaN input returns quieted A when both are NaN. When only one is NaN it returns the other operand unchanged, even if the NaN was signaling.
- R6: Policy 11 with any NaN input returns B unchanged.
- R7: With mode bit 2 = 1 and differing magnitudes (bits 62:0), the operand with the smaller (min) or larger (max) magnitude is returned. With equal magnitudes the R1 signed ordering decides.
- R8: With mode bit 2 = 1 and policy 11, a zero magnitude compares as +0, so two zeros of any sign tie and return B.
- R9: In every mode except that of R8, -0.0 orders below +0.0: minimum returns the -0.0 operand and maximum returns the +0.0 operand.
- R10: snan_seen is 1 exactly when at least one operand is a signaling NaN, in every mode.
- R11: wr_en is 1 exactly when trap_en is 0 and snan_seen is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | Operand A, binary64 bit pattern |
| op_b | input | 64 | Operand B, binary64 bit pattern |
| mode | input | 4 | Bit 3 max/min, bit 2 magnitude compare, bits 1:0 NaN policy |
| trap_en | input | 1 | Invalid-operation trapping enabled |
| result | output | 64 | Selected or quieted value |
| wr_en | output | 1 | Result may be written back |
| snan_seen | output | 1 | A signaling NaN was present on an input |

## Verification
The assertions check the following on every input change:
- the signaling-NaN flag and the write gate;
- that a NaN-free compare always returns one of the two operands;
- that the propagating policy always yields a quiet NaN;
- that the plain policy passes B through;
- that the 2019 number-preferring policy returns the non-NaN side.

The exact choice between operands cannot be shown by an invariant over a single input set. This covers sign-magnitude ordering, the ±0 and equal-magnitude ties, the magnitude compare and the NaN priority order of the 2008 policy. These are shown only by the bench's table of hand-derived vectors and by its real-valued reference model over randomized special values in all sixteen modes.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [1:0] {
    NP_NUM08  = 2'b00,
    NP_PROP19 = 2'b01,
    NP_NUM19  = 2'b10,
    NP_PLAIN  = 2'b11
  } nan_policy_e;

  // Field order matches the mode input: bit 3 max, bit 2 magnitude, bits 1:0 policy.
  typedef struct packed {
    logic        want_max;
    logic        by_mag;
    nan_policy_e policy;
  } mode_t;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic mag_zero;
  } op_flags_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [FP_W-1:0] op,
  output op_flags_t       flags,
  output logic [FP_W-1:0] mag,
  output logic [FP_W-1:0] quieted
);

  localparam logic [FP_W-1:0] INF_MAG = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam int QBIT = FRAC_W - 1;

  always_comb begin
    mag            = {1'b0, op[FP_W-2:0]};
    flags.is_nan   = (mag > INF_MAG);
    flags.is_snan  = flags.is_nan & ~op[QBIT];
    flags.mag_zero = (mag == '0);
    quieted        = op;
    quieted[QBIT]  = 1'b1;
  end

endmodule

// File: rtl/fmm_order_select.sv
module fmm_order_select #(
  parameter int FP_W = 64
) (
  input  logic [FP_W-1:0] op_a,
  input  logic [FP_W-1:0] op_b,
  input  logic [FP_W-1:0] mag_a,
  input  logic [FP_W-1:0] mag_b,
  input  logic            zero_a,
  input  logic            zero_b,
  input  logic            by_mag,
  input  logic            plain_cmp,
  input  logic            want_max,
  output logic            pick_a
);

  logic [FP_W-1:0] lhs_raw, rhs_raw;
  logic [FP_W-1:0] lhs, rhs;

  // Sign-magnitude less-than on raw bit patterns.
  function automatic logic sm_less(input logic [FP_W-1:0] l, input logic [FP_W-1:0] r);
    logic ls, rs;
    ls = l[FP_W-1];
    rs = r[FP_W-1];
    if (ls && !rs)      sm_less = 1'b1;
    else if (!ls && rs) sm_less = 1'b0;
    else if (ls)        sm_less = (l > r);
    else                sm_less = (l < r);
  endfunction

  always_comb begin
    lhs_raw = op_a;
    rhs_raw = op_b;
    if (by_mag) begin
      if (mag_a != mag_b) begin
        lhs_raw = mag_a;
        rhs_raw = mag_b;
      end
      if (plain_cmp) begin
        if (zero_a) lhs_raw = '0;
        if (zero_b) rhs_raw = '0;
      end
    end
  end

  // One comparator serves both directions: operands swap for maximum.
  always_comb begin
    if (want_max) begin
      lhs = rhs_raw;
      rhs = lhs_raw;
    end else begin
      lhs = lhs_raw;
      rhs = rhs_raw;
    end
    pick_a = sm_less(lhs, rhs);
  end

endmodule

// File: rtl/fmm_nan_select.sv
module fmm_nan_select
  import fmm_pkg::*;
#(
  parameter int FP_W = 64
) (
  input  nan_policy_e     policy,
  input  op_flags_t       flg_a,
  input  op_flags_t       flg_b,
  input  logic [FP_W-1:0] op_a,
  input  logic [FP_W-1:0] op_b,
  input  logic [FP_W-1:0] quiet_a,
  input  logic [FP_W-1:0] quiet_b,
  output logic [FP_W-1:0] nan_result
);

  logic both_nan;
  logic [FP_W-1:0] number_side;

  always_comb begin
    both_nan    = flg_a.is_nan & flg_b.is_nan;
    number_side = flg_a.is_nan ? op_b : op_a;
    unique case (policy)
      NP_NUM08: begin
        if (flg_a.is_snan)      nan_result = quiet_a;
        else if (flg_b.is_snan) nan_result = quiet_b;
        else if (both_nan)      nan_result = quiet_a;
        else                    nan_result = number_side;
      end
      NP_PROP19: nan_result = flg_a.is_nan ? quiet_a : quiet_b;
      NP_NUM19:  nan_result = both_nan ? quiet_a : number_side;
      default:   nan_result = op_b;
    endcase
  end

endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [FP_W-1:0]   op_a,
  input  logic [FP_W-1:0]   op_b,
  input  logic [MODE_W-1:0] mode,
  input  logic              trap_en,
  output logic [FP_W-1:0]   result,
  output logic              wr_en,
  output logic              snan_seen
);

  localparam int N_OPS = 2;

  mode_t           md;
  logic [FP_W-1:0] ops   [N_OPS];
  logic [FP_W-1:0] mags  [N_OPS];
  logic [FP_W-1:0] quiet [N_OPS];
  op_flags_t       flg   [N_OPS];
  logic            pick_a;
  logic            any_nan;
  logic [FP_W-1:0] nan_res;

  assign md     = mode_t'(mode);
  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op      (ops[i]),
      .flags   (flg[i]),
      .mag     (mags[i]),
      .quieted (quiet[i])
    );
  end

  fmm_order_select #(.FP_W(FP_W)) u_ord (
    .op_a      (op_a),
    .op_b      (op_b),
    .mag_a     (mags[0]),
    .mag_b     (mags[1]),
    .zero_a    (flg[0].mag_zero),
    .zero_b    (flg[1].mag_zero),
    .by_mag    (md.by_mag),
    .plain_cmp (md.policy == NP_PLAIN),
    .want_max  (md.want_max),
    .pick_a    (pick_a)
  );

  fmm_nan_select #(.FP_W(FP_W)) u_nan (
    .policy     (md.policy),
    .flg_a      (flg[0]),
    .flg_b      (flg[1]),
    .op_a       (op_a),
    .op_b       (op_b),
    .quiet_a    (quiet[0]),
    .quiet_b    (quiet[1]),
    .nan_result (nan_res)
  );

  always_comb begin
    any_nan   = flg[0].is_nan | flg[1].is_nan;
    snan_seen = flg[0].is_snan | flg[1].is_snan;
    wr_en     = ~trap_en & ~snan_seen;
    if (any_nan)     result = nan_res;
    else if (pick_a) result = op_a;
    else             result = op_b;
  end

endmodule

// File: rtl/fmm_unit_chk.sv
module fmm_unit_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
  input logic [FP_W-1:0] op_a,
  input logic [FP_W-1:0] op_b,
  input logic [3:0]      mode,
  input logic            trap_en,
  input logic [FP_W-1:0] result,
  input logic            wr_en,
  input logic            snan_seen
);

  localparam int QBIT = FRAC_W - 1;

  logic a_nan, b_nan, a_sn, b_sn, r_nan;

  always_comb begin
    a_nan = (&op_a[FP_W-2:FRAC_W]) && (|op_a[FRAC_W-1:0]);
    b_nan = (&op_b[FP_W-2:FRAC_W]) && (|op_b[FRAC_W-1:0]);
    r_nan = (&result[FP_W-2:FRAC_W]) && (|result[FRAC_W-1:0]);
    a_sn  = a_nan && !op_a[QBIT];
    b_sn  = b_nan && !op_b[QBIT];

    a_r10_snan_flag: assert (snan_seen == (a_sn || b_sn))
      else $error("snan_seen mismatch");
    a_r11_trap_blocks: assert (!(trap_en && wr_en))
      else $error("write while trapping");
    a_r11_snan_blocks: assert (!((a_sn || b_sn) && wr_en))
      else $error("write with sNaN input");
    a_r11_clean_writes: assert (trap_en || a_sn || b_sn || wr_en)
      else $error("write dropped without cause");
    a_r1_pick_operand: assert (a_nan || b_nan || result == op_a || result == op_b)
      else $error("result is neither operand");
    a_r4_quiet_nan: assert (!(mode[1:0] == 2'b01 && (a_nan || b_nan)) || (r_nan && result[QBIT]))
      else $error("propagating policy lost the NaN");
    a_r6_plain_b: assert (!(mode[1:0] == 2'b11 && (a_nan || b_nan)) || result == op_b)
      else $error("plain policy not B");
    a_r5_single_nan: assert (!(mode[1:0] == 2'b10 && (a_nan != b_nan)) || result == (a_nan ? op_b : op_a))
      else $error("number-preferring policy did not pick number");
  end

endmodule

bind fmm_unit fmm_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .mode      (mode),
  .trap_en   (trap_en),
  .result    (result),
  .wr_en     (wr_en),
  .snan_seen (snan_seen)
);

// File: tb/fmm_unit_tb.sv
module fmm_unit_tb;

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QN   = 64'h7FF8000000000001;
  localparam logic [63:0] SN   = 64'h7FF0000000000001;
  localparam logic [63:0] SNQ  = 64'h7FF8000000000001;
  localparam logic [63:0] SN2  = 64'hFFF0000000000002;
  localparam logic [63:0] SN2Q = 64'hFFF8000000000002;
  localparam logic [63:0] QN2  = 64'hFFF8000000000003;
  localparam logic [63:0] SUB  = 64'h0000000000000001;

  localparam int NV = 26;
  // {mode, a, b, expected result, expected snan}
  localparam logic [196:0] VEC [NV] = '{
    {4'd0,  P1,   N2,   N2,   1'b0},  // R1
    {4'd8,  P1,   N2,   P1,   1'b0},  // R1
    {4'd0,  NZ,   PZ,   NZ,   1'b0},  // R9
    {4'd8,  NZ,   PZ,   PZ,   1'b0},  // R9
    {4'd0,  QN,   P1,   P1,   1'b0},  // R3
    {4'd0,  SN,   P1,   SNQ,  1'b1},  // R2
    {4'd0,  QN,   SN2,  SN2Q, 1'b1},  // R3
    {4'd0,  QN,   QN2,  QN,   1'b0},  // R3
    {4'd1,  P1,   SN2,  SN2Q, 1'b1},  // R4
    {4'd9,  QN,   SN2,  QN,   1'b1},  // R4
    {4'd2,  SN,   P1,   P1,   1'b1},  // R5
    {4'd2,  SN,   QN2,  SNQ,  1'b1},  // R5
    {4'd3,  QN,   P1,   P1,   1'b0},  // R6
    {4'd11, P1,   QN,   QN,   1'b0},  // R6
    {4'd4,  N2,   P1,   P1,   1'b0},  // R7
    {4'd12, N2,   P1,   N2,   1'b0},  // R7
    {4'd4,  N1,   P1,   N1,   1'b0},  // R7
    {4'd12, N1,   P1,   P1,   1'b0},  // R7
    {4'd7,  NZ,   PZ,   PZ,   1'b0},  // R8
    {4'd15, PZ,   NZ,   NZ,   1'b0},  // R8
    {4'd3,  NZ,   PZ,   NZ,   1'b0},  // R9
    {4'd0,  SUB,  PZ,   PZ,   1'b0},  // R1
    {4'd8,  SUB,  PZ,   SUB,  1'b0},  // R1
    {4'd9,  NINF, PINF, PINF, 1'b0},  // R1
    {4'd0,  NINF, QN,   NINF, 1'b0},  // R3
    {4'd14, PINF, NINF, PINF, 1'b0}   // R7
  };

  logic        clk;
  logic [63:0] op_a, op_b, result;
  logic [3:0]  mode;
  logic        trap_en, wr_en, snan_seen;
  int          checks, errors;
  bit          done;

  fmm_unit u_dut (
    .op_a(op_a), .op_b(op_b), .mode(mode), .trap_en(trap_en),
    .result(result), .wr_en(wr_en), .snan_seen(snan_seen)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string row_tag(input int i);
    case (i)
      0, 1, 21, 22, 23:       row_tag = "R1";
      5:                      row_tag = "R2";
      4, 6, 7, 24:            row_tag = "R3";
      8, 9:                   row_tag = "R4";
      10, 11:                 row_tag = "R5";
      12, 13:                 row_tag = "R6";
      14, 15, 16, 17, 25:     row_tag = "R7";
      18, 19:                 row_tag = "R8";
      default:                row_tag = "R9";
    endcase
  endfunction

  function automatic bit is_nan(input logic [63:0] x);
    is_nan = (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [63:0] x);
    is_snan = is_nan(x) && !x[51];
  endfunction

  function automatic logic [63:0] qz(input logic [63:0] x);
    qz = x | 64'h0008000000000000;
  endfunction

  // Reference model written from the requirements using real arithmetic.
  function automatic logic [63:0] ref_mm(input logic [3:0] m, input logic [63:0] a, input logic [63:0] b);
    real ra, rb, ma, mb;
    bit  mx;
    mx = m[3];
    if (is_nan(a) || is_nan(b)) begin
      case (m[1:0])
        2'b00: begin
          if (is_snan(a))                  return qz(a);
          else if (is_snan(b))             return qz(b);
          else if (is_nan(a) && is_nan(b)) return qz(a);
          else                             return is_nan(a) ? b : a;
        end
        2'b01: return is_nan(a) ? qz(a) : qz(b);
        2'b10: begin
          if (is_nan(a) && is_nan(b)) return qz(a);
          return is_nan(a) ? b : a;
        end
        default: return b;
      endcase
    end
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (m[2]) begin
      ma = (ra < 0.0) ? -ra : ra;
      mb = (rb < 0.0) ? -rb : rb;
      if (ma != mb) return (mx ? (ma > mb) : (ma < mb)) ? a : b;
      if (m[1:0] == 2'b11 && ma == 0.0) return b;
    end
    if (ra != rb) return (mx ? (ra > rb) : (ra < rb)) ? a : b;
    if (a[63] != b[63]) return (mx ^ a[63]) ? a : b;
    return b;
  endfunction

  function automatic logic [63:0] gen_op(input int sel);
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    case (sel)
      1: v = {v[63], 63'd0};
      2: v = {v[63], 11'h7FF, 52'd0};
      3: v = {v[63], 11'h7FF, 1'b1, v[50:0]};
      4: v = {v[63], 11'h7FF, 1'b0, v[50:1], 1'b1};
      5: v = {v[63], 11'h000, v[51:0]};
      6: v = {v[63], 11'h3FF, 52'd0};
      default: ;
    endcase
    return v;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d a=%h b=%h actual=%h expected=%h", tag, mode, op_a, op_b, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d a=%h b=%h actual=%0b expected=%0b", tag, mode, op_a, op_b, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] m, input logic [63:0] a, input logic [63:0] b, input logic t);
    @(negedge clk);
    mode = m; op_a = a; op_b = b; trap_en = t;
    #1;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    mode = '0; op_a = '0; op_b = '0; trap_en = 1'b0;

    // Idle state: all-zero inputs give B, a write, and no flag.
    apply(4'd0, PZ, PZ, 1'b0);
    check64("R1 idle result", result, PZ);
    check1("R11 idle write", wr_en, 1'b1);
    check1("R10 idle flag", snan_seen, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][196:193], VEC[i][192:129], VEC[i][128:65], 1'b0);
      check64(row_tag(i), result, VEC[i][64:1]);
      check1("R10 table flag", snan_seen, VEC[i][0]);
    end

    // Write gate corner cases (R11).
    apply(4'd0, P1, N1, 1'b1);
    check1("R11 trap blocks write", wr_en, 1'b0);
    apply(4'd10, SN, P1, 1'b0);
    check1("R11 sNaN blocks write", wr_en, 1'b0);
    check1("R10 sNaN under policy 10", snan_seen, 1'b1);
    apply(4'd3, QN, QN2, 1'b0);
    check1("R11 quiet NaN still writes", wr_en, 1'b1);
    check1("R10 quiet NaN no flag", snan_seen, 1'b0);

    // Randomized sweep of all modes against the reference model.
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 300; k++) begin
        logic [63:0] a, b;
        logic        t;
        int          sb;
        a  = gen_op($urandom_range(0, 7));
        sb = $urandom_range(0, 8);
        if (sb == 8) b = a ^ 64'h8000000000000000;
        else         b = gen_op(sb);
        t = $urandom_range(0, 3) == 0;
        apply(m[3:0], a, b, t);
        check64("R1/R7 model result", result, ref_mm(m[3:0], a, b));
        check1("R10 model flag", snan_seen, is_snan(a) || is_snan(b));
        check1("R11 model write", wr_en, !t && !(is_snan(a) || is_snan(b)));
      end
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule